// File: doc/BRIEF.md
# Edge-Triggered DMA Burst Request Generator

This block contains four independent request-generator channels that sit in front of a DMA request multiplexer. Each channel watches one of 32 trigger inputs. When the selected input shows a qualifying edge, the channel raises a request line and holds it until the DMA side has acknowledged a programmed number of transfers. The edge can be rising, falling, either, or none. The burst length is stored as the count minus one.

If a qualifying edge arrives while the previous burst still has requests outstanding, the new edge is dropped and the channel's overrun flag is set. The flags of all four channels sit in one shared status vector. Software clears a flag by writing a one to the matching bit of a shared clear address. One interrupt line is raised while any flag is set and that channel's overrun interrupt enable is on.

Software controls everything through a single write port. Each channel has one control word, and one further address is the clear register.

Top module: `trg_req_gen`

## Requirements
- R1: Write addresses 0 to 3 load the control word of channel 0 to 3, and address 4 is the overrun clear register. Control word layout: bits [4:0] trigger select, [6:5] edge mode, [11:7] burst length minus one, [12] channel enable, [13] overrun interrupt enable.
- R2: A channel reacts only to trigger input `trig_in[sel]`. Edges on any other trigger input have no effect on its request line.
- R3: Edge mode encoding is 0 = no event, 1 = rising, 2 = falling, 3 = both. An event is detected at the first clock edge where the sampled level of the selected input differs from the previous sample in the selected direction. The request line is high from the following cycle.
- R4: The request line stays high until acknowledged. Each cycle with `ack` high while `req` is high counts one transfer. `req` falls after burst-minus-one + 1 such cycles, so field value 31 gives 32 transfers. `ack` while `req` is low is ignored.
- R5: A qualifying edge while a burst is outstanding sets the channel's overrun flag at `ovr_flags[ch]`, and the edge is dropped without starting another burst. This includes the cycle in which the last acknowledge is taken.
- R6: Writing address 4 with data bit ch = 1 clears overrun flag ch, and zero bits leave flags unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R7: `irq` is high exactly when some channel has its overrun flag set and its overrun interrupt enable bit on.
- R8: Clearing the enable bit aborts an outstanding burst, and `req` is low from the second clock edge after the write. It also discards the edge history: in the first enabled cycle after re-enabling, the level of the trigger input is only sampled and cannot produce an event.
- R9: After reset all request lines, overrun flags and `irq` are low and all control words are zero (channels disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0..3 control, 4 clear) |
| wr_data | input | 14 | Write data |
| trig_in | input | 32 | Trigger inputs shared by all channels |
| ack | input | 4 | Per-channel transfer acknowledge |
| req | output | 4 | Per-channel DMA request |
| ovr_flags | output | 4 | Overrun status, bit ch for channel ch |
| irq | output | 1 | Overrun interrupt |

## Verification
Two pairs of events can land on the same clock edge. In the first, the final acknowledge of a burst coincides with a fresh qualifying trigger edge. The bench drives `ack` and toggles the trigger on the same falling clock edge, then checks that the overrun flag is set and that no new burst starts. In the second, an overrun set coincides with a clear write for the same channel. The bench issues the clear write in the same cycle as an overrun-producing edge and expects the flag to survive. A scoreboard records the burst length expected for each trigger and compares it with the number of handshakes counted when the request line falls.

// File: rtl/trg_gen_pkg.sv
package trg_gen_pkg;
  localparam int SEL_W  = 5;
  localparam int CNT_W  = 5;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  // control word, MSB first: ovie, en, burst_m1, mode, sel
  typedef struct packed {
    logic             ovie;
    logic             en;
    logic [CNT_W-1:0] burst_m1;
    edge_mode_e       mode;
    logic [SEL_W-1:0] sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic edge_hit(edge_mode_e m, logic prev, logic cur);
    case (m)
      EDGE_RISE: return !prev && cur;
      EDGE_FALL: return prev && !cur;
      EDGE_ANY:  return prev ^ cur;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [CNT_W:0] burst_len(logic [CNT_W-1:0] m1);
    return {1'b0, m1} + 1'b1;
  endfunction
endpackage

// File: rtl/trg_edge_det.sv
module trg_edge_det
  import trg_gen_pkg::*;
#(
  parameter int NUM_TRIG = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [SEL_W-1:0]    sel,
  input  edge_mode_e          mode,
  input  logic [NUM_TRIG-1:0] trig,
  output logic                hit
);
  logic cur;
  logic prev_q;
  logic hist_vld_q;

  assign cur = trig[sel];
  assign hit = en && hist_vld_q && edge_hit(mode, prev_q, cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= 1'b0;
      hist_vld_q <= 1'b0;
    end else if (!en) begin
      prev_q     <= 1'b0;
      hist_vld_q <= 1'b0;
    end else begin
      prev_q     <= cur;
      hist_vld_q <= 1'b1;
    end
  end
endmodule

// File: rtl/trg_burst_ctr.sv
module trg_burst_ctr
  import trg_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hit,
  input  logic             ack,
  input  logic [CNT_W-1:0] burst_m1,
  output logic             req,
  output logic             start,
  output logic             ovr_set,
  output logic             done
);
  logic [CNT_W:0] remain_q;
  logic           busy;
  logic           take;

  assign busy    = (remain_q != '0);
  assign start   = hit && !busy;
  assign ovr_set = hit && busy;
  assign take    = busy && ack;
  assign done    = take && (remain_q == {{CNT_W{1'b0}}, 1'b1});
  assign req     = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remain_q <= '0;
    else if (!en)    remain_q <= '0;
    else if (start)  remain_q <= burst_len(burst_m1);
    else if (take)   remain_q <= remain_q - 1'b1;
  end
endmodule

// File: rtl/trg_chan.sv
module trg_chan
  import trg_gen_pkg::*;
#(
  parameter int CH       = 0,
  parameter int NUM_TRIG = 32,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CTRL_W-1:0]   wr_data,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic                ack,
  output logic                req,
  output logic                start,
  output logic                ovr_set,
  output logic                done,
  output logic                en,
  output logic                ovie
);
  ctrl_t ctrl_q;
  logic  hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(CH)) ctrl_q <= ctrl_t'(wr_data);
  end

  assign en   = ctrl_q.en;
  assign ovie = ctrl_q.ovie;

  trg_edge_det #(.NUM_TRIG(NUM_TRIG)) u_edge (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .sel(ctrl_q.sel),
    .mode(ctrl_q.mode), .trig(trig_in), .hit(hit)
  );

  trg_burst_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .hit(hit), .ack(ack),
    .burst_m1(ctrl_q.burst_m1), .req(req), .start(start),
    .ovr_set(ovr_set), .done(done)
  );
endmodule

// File: rtl/trg_req_gen.sv
module trg_req_gen
  import trg_gen_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_TRIG = 32,
  parameter int ADDR_W   = $clog2(NUM_CH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CTRL_W-1:0]   wr_data,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [NUM_CH-1:0]   ack,
  output logic [NUM_CH-1:0]   req,
  output logic [NUM_CH-1:0]   ovr_flags,
  output logic                irq
);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(NUM_CH);

  // named internal events for the checker
  logic [NUM_CH-1:0] start_ev;
  logic [NUM_CH-1:0] ovr_ev;
  logic [NUM_CH-1:0] done_ev;
  logic [NUM_CH-1:0] clr_ev;
  logic [NUM_CH-1:0] en_vec;
  logic [NUM_CH-1:0] ovie_vec;
  logic [NUM_CH-1:0] flags_q;

  assign clr_ev = (wr_en && wr_addr == CLR_ADDR) ? wr_data[NUM_CH-1:0] : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    trg_chan #(.CH(c), .NUM_TRIG(NUM_TRIG), .ADDR_W(ADDR_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .trig_in(trig_in), .ack(ack[c]),
      .req(req[c]), .start(start_ev[c]), .ovr_set(ovr_ev[c]),
      .done(done_ev[c]), .en(en_vec[c]), .ovie(ovie_vec[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= ovr_ev | (flags_q & ~clr_ev);
  end

  assign ovr_flags = flags_q;
  assign irq       = |(flags_q & ovie_vec);
endmodule

// File: rtl/trg_req_gen_chk.sv
module trg_req_gen_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req,
  input logic [NUM_CH-1:0] ack,
  input logic [NUM_CH-1:0] ovr_flags,
  input logic              irq,
  input logic [NUM_CH-1:0] start_ev,
  input logic [NUM_CH-1:0] ovr_ev,
  input logic [NUM_CH-1:0] clr_ev,
  input logic [NUM_CH-1:0] en_vec
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_a
    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req[g]) |-> ($past(ack[g]) || !en_vec[g]));
    // R3
    req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req[g]) |-> $past(start_ev[g]));
    // R5
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_ev[g] |=> ovr_flags[g]);
    // R6
    ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ev[g] && !ovr_ev[g]) |=> !ovr_flags[g]);
  end
  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flags == '0) |-> !irq);
endmodule

bind trg_req_gen trg_req_gen_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/trg_req_gen_test.sv
module trg_req_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [13:0] wr_data = '0;
  logic [31:0] trig_in = '0;
  logic [3:0]  ack = '0;
  logic [3:0]  req;
  logic [3:0]  ovr_flags;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct { int ch; int len; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  trg_req_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_in(trig_in), .ack(ack), .req(req),
    .ovr_flags(ovr_flags), .irq(irq)
  );

  task automatic check(bit ok, string tag, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [13:0] ctl(int sel, int mode, int bm1, bit en, bit ovie);
    return 14'((ovie << 13) | (en << 12) | (bm1 << 7) | (mode << 5) | sel);
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(int addr, logic [13:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(int ch, logic [13:0] d);
    wr(ch, d);
    @(negedge clk);
  endtask

  // driver: pushes the expected burst length, then makes the edge
  task automatic fire(int ch, int idx, int len);
    @(negedge clk);
    exp_q.push_back('{ch, len});
    trig_in[idx] = ~trig_in[idx];
  endtask

  task automatic ack_n(int ch, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ack[ch] = 1'b1;
      @(negedge clk); ack[ch] = 1'b0;
    end
  endtask

  // monitor: samples 1 ns before each rising edge
  initial begin
    int cnt [4];
    logic [3:0] prev_req;
    prev_req = '0;
    foreach (cnt[k]) cnt[k] = 0;
    forever begin
      @(negedge clk); #9;
      for (int c = 0; c < 4; c++) begin
        if (prev_req[c] && !req[c]) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected burst", cnt[c], 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.ch == c && e.len == cnt[c], "R4 burst length", cnt[c], e.len);
          end
          cnt[c] = 0;
        end
        if (req[c] && ack[c]) cnt[c]++;
      end
      prev_req = req;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    idle(2);
    // R9 reset state
    check(req == 0 && ovr_flags == 0 && !irq, "R9 reset", int'(req), 0);
    rst_n = 1'b1;
    idle(2);
    check(req == 0, "R9 disabled after reset", int'(req), 0);

    // R1 R3 R4: ch1 on trigger 31, rising, 3 requests; R2: other input ignored
    cfg(1, ctl(31, 1, 2, 1, 0));
    @(negedge clk); trig_in[5] = 1'b1;
    idle(2);
    check(req[1] == 1'b0, "R2 unselected input", int'(req[1]), 0);
    // R4 ack while idle ignored
    @(negedge clk); ack[1] = 1'b1; idle(3); ack[1] = 1'b0;
    check(req[1] == 1'b0, "R4 idle ack", int'(req[1]), 0);
    fire(1, 31, 3);
    idle(1);
    check(req[1] == 1'b1, "R3 rising starts", int'(req[1]), 1);
    ack_n(1, 3);
    idle(3);

    // R3 falling mode on ch2 trigger 0
    cfg(2, ctl(0, 2, 1, 1, 0));
    @(negedge clk); trig_in[0] = 1'b1;
    idle(2);
    check(req[2] == 1'b0, "R3 rise ignored in fall mode", int'(req[2]), 0);
    fire(2, 0, 2);
    idle(1);
    check(req[2] == 1'b1, "R3 falling starts", int'(req[2]), 1);
    // R5 R7: overrun with interrupt disabled
    @(negedge clk); trig_in[0] = 1'b1;
    @(negedge clk); trig_in[0] = 1'b0;
    idle(1);
    check(ovr_flags == 4'b0100, "R5 overrun ch2", int'(ovr_flags), 4);
    check(!irq, "R7 masked", int'(irq), 0);
    ack_n(2, 2);
    idle(3);
    wr(4, 14'b0100);
    idle(1);
    check(ovr_flags == 0, "R6 clear ch2", int'(ovr_flags), 0);

    // R3 mode none
    cfg(3, ctl(7, 0, 0, 1, 0));
    @(negedge clk); trig_in[7] = 1'b1;
    @(negedge clk); trig_in[7] = 1'b0;
    idle(2);
    check(req[3] == 1'b0, "R3 no-event mode", int'(req[3]), 0);
    // R4 maximum burst of 32
    cfg(3, ctl(7, 1, 31, 1, 0));
    fire(3, 7, 32);
    ack_n(3, 32);
    idle(3);
    check(req[3] == 1'b0, "R4 max burst ends", int'(req[3]), 0);

    // R5 R7 overrun on ch0, both edges, interrupt enabled
    cfg(0, ctl(3, 3, 1, 1, 1));
    fire(0, 3, 2);
    idle(2);
    @(negedge clk); trig_in[3] = ~trig_in[3];
    idle(1);
    check(ovr_flags == 4'b0001, "R5 overrun ch0", int'(ovr_flags), 1);
    check(irq, "R7 irq raised", int'(irq), 1);
    check(req[0] == 1'b1, "R5 burst continues", int'(req[0]), 1);
    ack_n(0, 2);
    idle(3);
    wr(4, 14'b1110);
    idle(1);
    check(ovr_flags == 4'b0001, "R6 zero bits keep flag", int'(ovr_flags), 1);
    wr(4, 14'b0001);
    idle(1);
    check(ovr_flags == 0 && !irq, "R6 clear ch0", int'(ovr_flags), 0);

    // R5 last ack and new edge in the same cycle
    cfg(0, ctl(3, 3, 0, 1, 1));
    fire(0, 3, 1);
    @(negedge clk); ack[0] = 1'b1; trig_in[3] = ~trig_in[3];
    @(negedge clk); ack[0] = 1'b0;
    check(ovr_flags[0] == 1'b1, "R5 edge on last ack", int'(ovr_flags[0]), 1);
    idle(3);
    check(req[0] == 1'b0, "R5 edge dropped", int'(req[0]), 0);
    wr(4, 14'b0001);

    // R6 set and clear in the same cycle
    cfg(0, ctl(3, 3, 1, 1, 1));
    fire(0, 3, 2);
    @(negedge clk);
    trig_in[3] = ~trig_in[3];
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 14'b0001;
    @(negedge clk); wr_en = 1'b0;
    check(ovr_flags[0] == 1'b1, "R6 set wins", int'(ovr_flags[0]), 1);
    ack_n(0, 2);
    idle(3);
    wr(4, 14'b0001);

    // R8 abort after one acknowledge
    cfg(1, ctl(31, 3, 3, 1, 0));
    fire(1, 31, 1);
    ack_n(1, 1);
    wr(1, ctl(31, 3, 3, 0, 0));
    idle(1);
    check(req[1] == 1'b0, "R8 abort", int'(req[1]), 0);
    // R8 history discarded: level changes while disabled
    @(negedge clk); trig_in[31] = ~trig_in[31];
    cfg(1, ctl(31, 3, 3, 1, 0));
    idle(3);
    check(req[1] == 1'b0, "R8 no stale edge", int'(req[1]), 0);
    idle(2);
    check(exp_q.size() == 0, "R4 all bursts seen", exp_q.size(), 0);
    finish_run();
  end
endmodule